// File: doc/BRIEF.md
# Selectable-Polynomial Serial CRC Engine

This block keeps a running cyclic redundancy check next to a serial shifter. Each time the shifter strobes a transferred bit, the engine folds that bit into a 16-bit register. It processes bits most-significant first and uses a Galois-form LFSR. A two-bit mode input picks the generator polynomial at run time. Three modes run a 16-bit check and one runs a 7-bit check.

Software can load the register directly or reset it to all ones with a one-cycle clear command. In full duplex the engine can follow either the outgoing or the incoming stream. Two status outputs report whether the active part of the register is all zeros or all ones. A frame check can read them without comparing the full value.

Top module: `spi_crc_engine`

## Requirements
- R1: After reset `crc_value` is 0xFFFF, `crc_nonzero` is 1 and `crc_not_ones` is 0.
- R2: Mode 00 is a 16-bit CRC with polynomial 0x1021. On an update, fb = d XOR crc[15], and the new value is (crc<<1) XOR (fb ? 0x1021 : 0). Starting from 0xFFFF, the ASCII string "123456789" gives 0x29B1.
- R3: Mode 01 is a 7-bit CRC with polynomial 0x09 on bits [6:0], with fb = d XOR crc[6]. Bits [15:7] keep their value across updates. Starting from 0, "123456789" gives 0x75.
- R4: Mode 10 is a 16-bit CRC with polynomial 0x8005, using the same update form as R2.
- R5: Mode 11 is a 16-bit CRC with polynomial 0x0001, using the same update form as R2.
- R6: The value changes by a bit update only in a cycle where both `crc_en` and `shift_vld` are 1. Otherwise it holds.
- R7: `crc_clr` loads 0xFFFF at the next edge, whatever the enable is. It wins over a write and over a strobe in the same cycle.
- R8: `wr_en` loads `wr_data` at the next edge. It wins over a strobe in the same cycle.
- R9: With `full_duplex`=1, the data bit is `rx_bit` when `rx_sel`=1 and `tx_bit` when `rx_sel`=0. With `full_duplex`=0, the data bit is always `tx_bit` and `rx_sel` has no effect.
- R10: `crc_nonzero` is 0 exactly when the active bits are all zero. The active bits are [6:0] in mode 01 and [15:0] otherwise.
- R11: `crc_not_ones` is 0 exactly when the active bits are all ones. The active bits are the same as in R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Polynomial select |
| crc_en | input | 1 | Allows bit updates |
| crc_clr | input | 1 | One-cycle command to load all ones |
| full_duplex | input | 1 | 1 when both streams are active |
| rx_sel | input | 1 | Picks the incoming stream in full duplex |
| shift_vld | input | 1 | One strobe per transferred bit |
| tx_bit | input | 1 | Outgoing serial bit (the only stream in half duplex) |
| rx_bit | input | 1 | Incoming serial bit |
| wr_en | input | 1 | Software load strobe |
| wr_data | input | 16 | Value to load |
| crc_value | output | 16 | Current CRC register |
| crc_nonzero | output | 1 | Active bits are not all zero |
| crc_not_ones | output | 1 | Active bits are not all ones |

## Verification
The bench sweeps all four modes with pseudo-random data, strobes, enables, stream selects, writes and clears. It compares every cycle against an arithmetic model. A swapped polynomial or a wrong feedback tap shows up as a wrong check value on the standard string. A 7-bit mode that shifts into bit 7 corrupts the preserved upper bits. Swapped clear/write/strobe priority loads the wrong value on the collision cycles. A stream mux that reads `rx_sel` in half duplex follows the idle line. Flags evaluated over all 16 bits in 7-bit mode misreport values such as 0xFF80 and 0x007F.

// File: rtl/crc_pkg.sv
package crc_pkg;

   typedef enum logic [1:0] {
      CRC_M_CCITT16 = 2'b00,
      CRC_M_SHORT7  = 2'b01,
      CRC_M_ALT16   = 2'b10,
      CRC_M_RSVD16  = 2'b11
   } crc_mode_e;

   localparam int unsigned CRC_NUM_MODES = 4;

   function automatic logic mode_is_short(input logic [1:0] m);
      return crc_mode_e'(m) == CRC_M_SHORT7;
   endfunction

endpackage

// File: rtl/crc_bit_step.sv
module crc_bit_step #(
   parameter int unsigned REG_W = 16,
   parameter int unsigned WIDTH = 16,
   parameter logic [REG_W-1:0] POLY = 16'h1021
) (
   input  logic [REG_W-1:0] cur,
   input  logic             din,
   output logic [REG_W-1:0] nxt
);
   localparam int unsigned TOP = WIDTH - 1;

   if (WIDTH < 2 || WIDTH > REG_W) begin : g_bad_width
      $error("crc_bit_step: WIDTH out of range");
   end

   logic             fb;
   logic [WIDTH-1:0] shifted;

   always_comb begin
      fb      = din ^ cur[TOP];
      shifted = {cur[TOP-1:0], 1'b0} ^ ({WIDTH{fb}} & POLY[WIDTH-1:0]);
   end

   if (WIDTH == REG_W) begin : g_full
      assign nxt = shifted;
   end else begin : g_part
      assign nxt = {cur[REG_W-1:WIDTH], shifted};
   end
endmodule

// File: rtl/crc_status.sv
module crc_status #(
   parameter int unsigned REG_W   = 16,
   parameter int unsigned SHORT_W = 7
) (
   input  logic [REG_W-1:0] cur,
   input  logic             short_sel,
   output logic             nonzero,
   output logic             not_ones
);
   if (SHORT_W < 2 || SHORT_W >= REG_W) begin : g_bad_short
      $error("crc_status: SHORT_W out of range");
   end

   logic [SHORT_W-1:0] low;
   assign low = cur[SHORT_W-1:0];

   always_comb begin
      if (short_sel) begin
         nonzero  = |low;
         not_ones = ~&low;
      end else begin
         nonzero  = |cur;
         not_ones = ~&cur;
      end
   end
endmodule

// File: rtl/spi_crc_engine.sv
module spi_crc_engine #(
   parameter int unsigned REG_W   = 16,
   parameter int unsigned SHORT_W = 7,
   parameter logic [REG_W-1:0] POLY_M0 = 16'h1021,
   parameter logic [REG_W-1:0] POLY_M1 = 16'h0009,
   parameter logic [REG_W-1:0] POLY_M2 = 16'h8005,
   parameter logic [REG_W-1:0] POLY_M3 = 16'h0001
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       mode,
   input  logic             crc_en,
   input  logic             crc_clr,
   input  logic             full_duplex,
   input  logic             rx_sel,
   input  logic             shift_vld,
   input  logic             tx_bit,
   input  logic             rx_bit,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] crc_value,
   output logic             crc_nonzero,
   output logic             crc_not_ones
);
   import crc_pkg::*;

   localparam logic [REG_W-1:0] ALL_ONES = {REG_W{1'b1}};

   if (REG_W < 8) begin : g_bad_reg
      $error("spi_crc_engine: REG_W too small");
   end

   logic [REG_W-1:0] crc_q;
   logic [REG_W-1:0] crc_d;
   logic             data_bit;
   logic             upd;
   logic [REG_W-1:0] step_res [CRC_NUM_MODES];

   // stream select: rx path only reachable in full duplex
   assign data_bit = (full_duplex && rx_sel) ? rx_bit : tx_bit;
   assign upd      = crc_en && shift_vld;

   for (genvar g = 0; g < CRC_NUM_MODES; g++) begin : g_mode
      localparam logic [REG_W-1:0] P =
         (g == 0) ? POLY_M0 : (g == 1) ? POLY_M1 : (g == 2) ? POLY_M2 : POLY_M3;
      localparam int unsigned W = (g == 1) ? SHORT_W : REG_W;
      crc_bit_step #(.REG_W(REG_W), .WIDTH(W), .POLY(P)) u_step (
         .cur (crc_q),
         .din (data_bit),
         .nxt (step_res[g])
      );
   end

   always_comb begin
      crc_d = crc_q;
      if (crc_clr)    crc_d = ALL_ONES;
      else if (wr_en) crc_d = wr_data;
      else if (upd)   crc_d = step_res[mode];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) crc_q <= ALL_ONES;
      else        crc_q <= crc_d;
   end

   assign crc_value = crc_q;

   crc_status #(.REG_W(REG_W), .SHORT_W(SHORT_W)) u_status (
      .cur       (crc_q),
      .short_sel (mode_is_short(mode)),
      .nonzero   (crc_nonzero),
      .not_ones  (crc_not_ones)
   );

   AST_CLEAR_LOADS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      crc_clr |=> crc_value == ALL_ONES); // R7
   AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      (!crc_clr && wr_en) |=> crc_value == $past(wr_data)); // R8
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!crc_clr && !wr_en && !(crc_en && shift_vld)) |=> $stable(crc_value)); // R6
   AST_SHORT_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (!crc_clr && !wr_en && mode == 2'b01)
      |=> crc_value[REG_W-1:SHORT_W] == $past(crc_value[REG_W-1:SHORT_W])); // R3
endmodule

// File: tb/spi_crc_engine_tb.sv
module spi_crc_engine_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  mode = 2'b00;
   logic        crc_en = 1'b0, crc_clr = 1'b0, full_duplex = 1'b0, rx_sel = 1'b0;
   logic        shift_vld = 1'b0, tx_bit = 1'b0, rx_bit = 1'b0, wr_en = 1'b0;
   logic [15:0] wr_data = 16'h0;
   logic [15:0] crc_value;
   logic        crc_nonzero, crc_not_ones;

   int checks = 0;
   int errors = 0;
   logic [15:0] exp_v = 16'hFFFF;
   logic [31:0] prbs = 32'h1ACE_B00C;

   always #5 clk = ~clk;

   spi_crc_engine u_dut (
      .clk(clk), .rst_n(rst_n), .mode(mode), .crc_en(crc_en), .crc_clr(crc_clr),
      .full_duplex(full_duplex), .rx_sel(rx_sel), .shift_vld(shift_vld),
      .tx_bit(tx_bit), .rx_bit(rx_bit), .wr_en(wr_en), .wr_data(wr_data),
      .crc_value(crc_value), .crc_nonzero(crc_nonzero), .crc_not_ones(crc_not_ones)
   );

   function automatic logic [15:0] act_mask(input logic [1:0] m);
      return (m == 2'b01) ? 16'h007F : 16'hFFFF;
   endfunction

   function automatic logic [15:0] ref_step(input logic [15:0] c, input logic [1:0] m, input logic d);
      logic [15:0] p, msk, r;
      logic fb;
      p   = (m == 0) ? 16'h1021 : (m == 1) ? 16'h0009 : (m == 2) ? 16'h8005 : 16'h0001;
      msk = act_mask(m);
      fb  = d ^ ((m == 1) ? c[6] : c[15]);
      r   = ((c << 1) ^ (fb ? p : 16'h0)) & msk;
      return r | (c & ~msk);
   endfunction

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic chk_flags(input string tag);
      logic [15:0] m;
      m = act_mask(mode);
      chk({tag, " R10"}, {15'h0, crc_nonzero}, {15'h0, (exp_v & m) != 16'h0});
      chk({tag, " R11"}, {15'h0, crc_not_ones}, {15'h0, (exp_v & m) != m});
   endtask

   // apply one cycle of stimulus, update model, sample 1 ns after the edge
   task automatic cyc(input logic clr, input logic wr, input logic [15:0] wd,
                      input logic en, input logic vld, input logic fd,
                      input logic rs, input logic tb, input logic rb);
      logic d;
      crc_clr = clr; wr_en = wr; wr_data = wd; crc_en = en; shift_vld = vld;
      full_duplex = fd; rx_sel = rs; tx_bit = tb; rx_bit = rb;
      d = (fd && rs) ? rb : tb;
      if (clr)            exp_v = 16'hFFFF;
      else if (wr)        exp_v = wd;
      else if (en && vld) exp_v = ref_step(exp_v, mode, d);
      @(posedge clk); #1;
      crc_clr = 1'b0; wr_en = 1'b0; shift_vld = 1'b0;
   endtask

   task automatic shift_byte(input logic [7:0] b);
      for (int i = 7; i >= 0; i--) cyc(0, 0, 16'h0, 1, 1, 0, 0, b[i], 1'b0);
   endtask

   task automatic shift_string();
      string s;
      s = "123456789";
      for (int i = 0; i < s.len(); i++) shift_byte(s[i]);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R1 reset value", crc_value, 16'hFFFF);
      chk("R1 nonzero", {15'h0, crc_nonzero}, 16'h1);
      chk("R1 not_ones", {15'h0, crc_not_ones}, 16'h0);
      rst_n = 1'b1;
      @(posedge clk); #1;

      // R2 standard check value
      mode = 2'b00;
      cyc(1, 0, 16'h0, 0, 0, 0, 0, 0, 0);
      shift_string();
      chk("R2 check string", crc_value, 16'h29B1);
      chk("R2 model", crc_value, exp_v);

      // R3 standard check value, upper bits preserved
      mode = 2'b01;
      cyc(0, 1, 16'hA500, 0, 0, 0, 0, 0, 0);
      shift_string();
      chk("R3 check string", crc_value & 16'h007F, 16'h0075);
      chk("R3 upper kept", crc_value & 16'hFF80, 16'hA500);

      // R7 priority over write and strobe
      cyc(1, 1, 16'h1234, 1, 1, 0, 0, 1, 0);
      chk("R7 clear wins", crc_value, 16'hFFFF);
      cyc(0, 1, 16'h1234, 1, 1, 0, 0, 1, 0);
      chk("R8 write wins", crc_value, 16'h1234);
      cyc(1, 0, 16'h0, 0, 0, 0, 0, 0, 0);
      chk("R7 clear without enable", crc_value, 16'hFFFF);

      // R6 holds
      mode = 2'b00;
      cyc(0, 1, 16'h5A5A, 0, 0, 0, 0, 0, 0);
      cyc(0, 0, 16'h0, 0, 1, 0, 0, 1, 1);
      chk("R6 en low holds", crc_value, 16'h5A5A);
      cyc(0, 0, 16'h0, 1, 0, 0, 0, 1, 1);
      chk("R6 no strobe holds", crc_value, 16'h5A5A);

      // R9 half duplex ignores rx_sel
      cyc(0, 1, 16'h0000, 0, 0, 0, 0, 0, 0);
      cyc(0, 0, 16'h0, 1, 1, 0, 1, 1'b0, 1'b1);
      chk("R9 half duplex uses tx", crc_value, 16'h0000);
      cyc(0, 0, 16'h0, 1, 1, 1, 1, 1'b0, 1'b1);
      chk("R9 full duplex rx", crc_value, 16'h1021);

      // R10 R11 flag corners
      mode = 2'b01;
      cyc(0, 1, 16'hFF80, 0, 0, 0, 0, 0, 0);
      chk_flags("short low zero");
      cyc(0, 1, 16'h007F, 0, 0, 0, 0, 0, 0);
      chk_flags("short low ones");
      mode = 2'b00;
      #1; chk_flags("full 007F");
      cyc(0, 1, 16'h0000, 0, 0, 0, 0, 0, 0);
      chk_flags("full zero");
      cyc(0, 1, 16'hFFFF, 0, 0, 0, 0, 0, 0);
      chk_flags("full ones");

      // sweep every mode with mixed stimulus
      for (int m = 0; m < 4; m++) begin
         string tag;
         mode = 2'(m);
         tag = (m == 0) ? "R2 sweep" : (m == 1) ? "R3 sweep" : (m == 2) ? "R4 sweep" : "R5 sweep";
         cyc(0, 1, 16'hC3A5 ^ 16'(m), 0, 0, 0, 0, 0, 0);
         for (int k = 0; k < 300; k++) begin
            prbs = {prbs[30:0], prbs[31] ^ prbs[21] ^ prbs[1] ^ prbs[0]};
            cyc((k % 53) == 17, (k % 29) == 11, prbs[31:16],
                prbs[0] | prbs[5], prbs[1] | prbs[6], prbs[2], prbs[3], prbs[4], prbs[7]);
            chk({tag, " R6 R9"}, crc_value, exp_v);
            chk_flags(tag);
         end
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule